// File: doc/BRIEF.md
# Powered-Device Discovery Sequencer

This block runs the discovery steps that one power-sourcing Ethernet port performs before it applies full power. It selects which probe voltage the analog front end should force on the port: off, 4 V, 8 V, 17.5 V or high impedance. It reads the digitized port current, given in microamps, at fixed points in that sequence. It decides whether the attached load shows a valid resistive signature. When classification is enabled, it sorts the measured class current into a 3-bit class code. When the block has finished, it asserts a request to grant power.

All waits are counted in ticks of a 1 ms strobe, so the sequence runs at whatever rate the system clock has. The detection test is done without a divider. The block takes the difference between the two current samples and checks whether it falls inside an accept window. A 4 V step across a 19 kΩ to 26.5 kΩ signature gives a difference of about 151 µA to 210 µA, which sets that window. In a midspan installation, the block waits in a high-impedance back-off after each failed detection, so that a second power source probing the same cable does not collide with it. A bypass input skips discovery entirely. Dropping the enable or undervoltage-ok input at any time returns the block to idle.

Top module: `pse_discovery_seq`

## Requirements
- R1: After reset, and while the block is idle, the probe select is 0 (off), the power grant is low and the class code is 111.
- R2: When the block is enabled with the bypass input low, the next clock edge starts detection with probe select 1 (4 V). Probe select stays 1 until the edge on which the 88th tick is counted. From that edge on, probe select is 2 (8 V), and the current sampled in that cycle is held as the first reading.
- R3: Probe select 2 is held for another 88 ticks. In the cycle of the last tick, the current being presented is taken as the second reading. The signature measure is the second reading minus the first reading.
- R4: Detection passes only if that difference lies between 151 µA and 210 µA inclusive. A difference below 151 µA, above 210 µA, or negative is a failure.
- R5: With the midspan input low, a failed detection returns the block directly to probe select 1, and the detection cycle repeats without limit.
- R6: With the midspan input high, a failed detection is followed by probe select 4 (high impedance) for 2800 ticks. After that, the block returns to probe select 1.
- R7: After a pass with the class-enable input high, the block drives probe select 3 (17.5 V) for 21 ticks, then raises the power grant with probe select 0. The grant stays high while the enable and undervoltage-ok inputs both remain high.
- R8: The class code is taken from the current presented in the last tick of classification. Below 6500 µA the code is 000. From 6500 µA it is 001, from 14500 µA it is 010, from 23000 µA it is 011, and from 33000 µA it is 100. At 46500 µA and above it is 000 again. The code 101 is never produced, and the code reads 111 whenever the grant is low.
- R9: After a pass with class-enable low, the block grants power straight away with class code 110.
- R10: If the bypass input is high when the block leaves idle, the power grant rises on the next edge and the class code stays 111.
- R11: If enable or undervoltage-ok is low at a clock edge, that edge returns the block to idle with the outputs described in R1, whatever state it was in.
- R12: Cycles without a tick do not advance any timed phase, so the probe select does not change while ticks are absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 1 ms timing strobe |
| enable | input | 1 | Port enable |
| uv_ok | input | 1 | Supply above undervoltage threshold |
| det_bypass | input | 1 | Skip detection and classification |
| class_en | input | 1 | Perform classification after a pass |
| midspan_en | input | 1 | Insert back-off after failed detection |
| isense_ua | input | IW | Port current in microamps |
| probe_sel | output | 3 | Requested probe: 0 off, 1 4 V, 2 8 V, 3 17.5 V, 4 high-Z |
| grant_pwr | output | 1 | Request to switch on port power |
| class_code | output | 3 | Class result or status code |

## Verification
The bench aims at the edges of the accept window: differences of exactly 151 and 210 µA must pass, and 150 and 211 µA must fail. A design with an off-by-one in either comparison would either power a bad load or keep probing a good one. A negative difference must fail. If the subtraction were unsigned, the wrapped value would not land in the window, but a reversed operand order would accept a falling current.

Each class threshold is driven at its exact value and one microamp below it. An inclusive/exclusive mix-up shows up as a code that is one class off. The value at the top of the range must read class 0, not class 4.

The bench holds the tick low for long stretches and also gives ticks sparsely. A timer that counted clocks instead of ticks would advance the probe early. An enable drop in the middle of the sequence must force idle on the next edge. The back-off length is checked at both of its ends.

// File: rtl/pse_seq_pkg.sv
package pse_seq_pkg;

    typedef enum logic [2:0] {
        PRB_OFF  = 3'd0,
        PRB_4V   = 3'd1,
        PRB_8V   = 3'd2,
        PRB_17V  = 3'd3,
        PRB_HIZ  = 3'd4
    } probe_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DET_LO,
        ST_DET_HI,
        ST_BACKOFF,
        ST_CLASSIFY,
        ST_POWER
    } seq_e;

    localparam logic [2:0] CODE_BUSY = 3'b111;
    localparam logic [2:0] CODE_SKIP = 3'b110;

    function automatic probe_e probe_of(input seq_e st);
        case (st)
            ST_DET_LO:   return PRB_4V;
            ST_DET_HI:   return PRB_8V;
            ST_CLASSIFY: return PRB_17V;
            ST_BACKOFF:  return PRB_HIZ;
            default:     return PRB_OFF;
        endcase
    endfunction

    function automatic logic is_timed(input seq_e st);
        return (st == ST_DET_LO) || (st == ST_DET_HI) ||
               (st == ST_BACKOFF) || (st == ST_CLASSIFY);
    endfunction

endpackage

// File: rtl/pse_tick_timer.sv
module pse_tick_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    assign done = run && tick && ((cnt_q + CW'(1)) == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || done)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/pse_sig_judge.sv
module pse_sig_judge #(
    parameter int IW     = 16,
    parameter int WIN_LO = 151,
    parameter int WIN_HI = 210
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic [IW-1:0] isense,
    output logic          pass
);
    logic [IW-1:0] first_q;
    logic [IW-1:0] delta;

    always_ff @(posedge clk) begin
        if (rst)
            first_q <= '0;
        else if (hold)
            first_q <= isense;
    end

    assign delta = isense - first_q;
    assign pass  = (isense >= first_q) &&
                   (delta >= IW'(WIN_LO)) && (delta <= IW'(WIN_HI));
endmodule

// File: rtl/pse_class_bin.sv
module pse_class_bin #(
    parameter int IW  = 16,
    parameter int NTH = 5,
    parameter int TH1 = 6500,
    parameter int TH2 = 14500,
    parameter int TH3 = 23000,
    parameter int TH4 = 33000,
    parameter int TH5 = 46500
) (
    input  logic [IW-1:0] isense,
    output logic [2:0]    code
);
    localparam int TH [NTH] = '{TH1, TH2, TH3, TH4, TH5};

    logic [NTH-1:0] above;

    for (genvar k = 0; k < NTH; k++) begin : g_cmp
        assign above[k] = (isense >= IW'(TH[k]));
    end

    always_comb begin
        if (&above)
            code = 3'b000;
        else
            code = 3'($countones(above));
    end
endmodule

// File: rtl/pse_discovery_seq.sv
module pse_discovery_seq
    import pse_seq_pkg::*;
#(
    parameter int IW         = 16,
    parameter int DET_TICKS  = 88,
    parameter int CLS_TICKS  = 21,
    parameter int BACK_TICKS = 2800,
    parameter int WIN_LO     = 151,
    parameter int WIN_HI     = 210
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          enable,
    input  logic          uv_ok,
    input  logic          det_bypass,
    input  logic          class_en,
    input  logic          midspan_en,
    input  logic [IW-1:0] isense_ua,
    output logic [2:0]    probe_sel,
    output logic          grant_pwr,
    output logic [2:0]    class_code
);
    localparam int MAXT = (BACK_TICKS > DET_TICKS) ?
                          ((BACK_TICKS > CLS_TICKS) ? BACK_TICKS : CLS_TICKS) :
                          ((DET_TICKS > CLS_TICKS) ? DET_TICKS : CLS_TICKS);
    localparam int CW = $clog2(MAXT + 1);

    seq_e          state_q, state_n;
    logic [2:0]    code_q, code_n;
    logic [CW-1:0] limit;
    logic          done;
    logic          pass;
    logic [2:0]    bin_code;
    logic          live;

    assign live = enable && uv_ok;

    always_comb begin
        case (state_q)
            ST_BACKOFF:  limit = CW'(BACK_TICKS);
            ST_CLASSIFY: limit = CW'(CLS_TICKS);
            default:     limit = CW'(DET_TICKS);
        endcase
    end

    pse_tick_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (live && is_timed(state_q)),
        .tick  (tick),
        .limit (limit),
        .done  (done)
    );

    pse_sig_judge #(.IW(IW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_judge (
        .clk    (clk),
        .rst    (rst),
        .hold   (state_q == ST_DET_LO && done),
        .isense (isense_ua),
        .pass   (pass)
    );

    pse_class_bin #(.IW(IW)) u_bin (
        .isense (isense_ua),
        .code   (bin_code)
    );

    always_comb begin
        state_n = state_q;
        code_n  = code_q;
        if (!live) begin
            state_n = ST_IDLE;
            code_n  = CODE_BUSY;
        end else begin
            case (state_q)
                ST_IDLE:
                    state_n = det_bypass ? ST_POWER : ST_DET_LO;
                ST_DET_LO:
                    if (done) state_n = ST_DET_HI;
                ST_DET_HI:
                    if (done) begin
                        if (!pass)
                            state_n = midspan_en ? ST_BACKOFF : ST_DET_LO;
                        else if (class_en)
                            state_n = ST_CLASSIFY;
                        else begin
                            state_n = ST_POWER;
                            code_n  = CODE_SKIP;
                        end
                    end
                ST_BACKOFF:
                    if (done) state_n = ST_DET_LO;
                ST_CLASSIFY:
                    if (done) begin
                        state_n = ST_POWER;
                        code_n  = bin_code;
                    end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= CODE_BUSY;
        end else begin
            state_q <= state_n;
            code_q  <= code_n;
        end
    end

    assign probe_sel  = probe_of(state_q);
    assign grant_pwr  = (state_q == ST_POWER);
    assign class_code = code_q;
endmodule

// File: rtl/pse_discovery_chk.sv
module pse_discovery_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       enable,
    input logic       uv_ok,
    input logic       det_bypass,
    input logic [2:0] probe_sel,
    input logic       grant_pwr,
    input logic [2:0] class_code
);
    assert_idle_on_drop_R11: assert property (@(posedge clk) disable iff (rst)
        !(enable && uv_ok) |=> (probe_sel == 3'd0 && !grant_pwr && class_code == 3'b111));

    assert_grant_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (grant_pwr && enable && uv_ok) |=> grant_pwr);

    assert_no_code_101_R8: assert property (@(posedge clk) disable iff (rst)
        class_code != 3'b101);

    assert_busy_code_R1: assert property (@(posedge clk) disable iff (rst)
        !grant_pwr |-> class_code == 3'b111);

    assert_hold_without_tick_R12: assert property (@(posedge clk) disable iff (rst)
        (!tick && enable && uv_ok && probe_sel != 3'd0) |=> $stable(probe_sel));

    assert_bypass_grant_R10: assert property (@(posedge clk) disable iff (rst)
        (enable && uv_ok && det_bypass && probe_sel == 3'd0 && !grant_pwr) |=> grant_pwr);
endmodule

bind pse_discovery_seq pse_discovery_chk u_chk (.*);

// File: tb/sim_pse_discovery_seq.sv
module sim_pse_discovery_seq;
    logic        clk = 0;
    logic        rst = 1;
    logic        tick = 0;
    logic        enable = 0, uv_ok = 1, det_bypass = 0, class_en = 1, midspan_en = 0;
    logic [15:0] isense_ua;
    logic [2:0]  probe_sel;
    logic        grant_pwr;
    logic [2:0]  class_code;

    int total = 0, fails = 0;
    int lo_ua = 0, hi_ua = 0, cls_ua = 0;
    int tick_mode = 1, cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign isense_ua = (probe_sel == 3'd1) ? 16'(lo_ua) :
                       (probe_sel == 3'd2) ? 16'(hi_ua) :
                       (probe_sel == 3'd3) ? 16'(cls_ua) : 16'd0;

    pse_discovery_seq u0 (
        .clk(clk), .rst(rst), .tick(tick), .enable(enable), .uv_ok(uv_ok),
        .det_bypass(det_bypass), .class_en(class_en), .midspan_en(midspan_en),
        .isense_ua(isense_ua), .probe_sel(probe_sel), .grant_pwr(grant_pwr),
        .class_code(class_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 low probe, 2 high probe, 3 back-off, 4 classify, 5 powered
    int ms = 0, mcnt = 0, mfirst = 0, mcode = 7;

    function automatic int mload();
        case (ms)
            1: return lo_ua;
            2: return hi_ua;
            4: return cls_ua;
            default: return 0;
        endcase
    endfunction

    function automatic int mbin(input int c);
        if (c < 6500) return 0;
        if (c < 14500) return 1;
        if (c < 23000) return 2;
        if (c < 33000) return 3;
        if (c < 46500) return 4;
        return 0;
    endfunction

    function automatic int mprobe();
        case (ms)
            1: return 1;
            2: return 2;
            3: return 4;
            4: return 3;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst || !(enable && uv_ok)) begin
            ms = 0; mcnt = 0; mcode = 7;
        end else begin
            case (ms)
                0: begin ms = det_bypass ? 5 : 1; mcnt = 0; end
                1: if (tick) begin
                       if (mcnt == 87) begin mfirst = mload(); mcnt = 0; ms = 2; end
                       else mcnt++;
                   end
                2: if (tick) begin
                       if (mcnt == 87) begin
                           int d;
                           d = mload() - mfirst;
                           mcnt = 0;
                           if (d >= 151 && d <= 210) begin
                               if (class_en) ms = 4;
                               else begin ms = 5; mcode = 6; end
                           end else
                               ms = midspan_en ? 3 : 1;
                       end else mcnt++;
                   end
                3: if (tick) begin
                       if (mcnt == 2799) begin mcnt = 0; ms = 1; end
                       else mcnt++;
                   end
                4: if (tick) begin
                       if (mcnt == 20) begin mcode = mbin(mload()); mcnt = 0; ms = 5; end
                       else mcnt++;
                   end
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        cyc++;
        tick = (tick_mode == 0) ? 1'b0 : (tick_mode == 1) ? 1'b1 : (cyc % 3 == 0);
        if (!rst && !finished) begin
            chk("R2 R3 R5 R6 probe vs model", int'(probe_sel), mprobe());
            chk("R7 R9 R10 grant vs model", int'(grant_pwr), (ms == 5) ? 1 : 0);
            chk("R8 R9 code vs model", int'(class_code), mcode);
        end
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input int lo, input int hi, input int cl,
                         input bit cen, input bit mid, input bit byp);
        @(negedge clk);
        enable = 0;
        @(negedge clk);
        lo_ua = lo; hi_ua = hi; cls_ua = cl;
        class_en = cen; midspan_en = mid; det_bypass = byp;
        enable = 1;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    int cls_in [7] = '{46499, 33000, 32999, 23000, 22999, 14500, 6499};
    int cls_ex [7] = '{4, 4, 3, 3, 2, 2, 0};

    initial begin
        waitn(3);
        rst = 0;
        waitn(1);
        chk("R1 reset probe", int'(probe_sel), 0);
        chk("R1 reset grant", int'(grant_pwr), 0);
        chk("R1 reset code", int'(class_code), 7);

        // lower window edge, lowest class threshold
        start(100, 251, 6500, 1, 0, 0);
        waitn(50);  chk("R2 low probe", int'(probe_sel), 1);
        waitn(70);  chk("R3 high probe", int'(probe_sel), 2);
        waitn(70);  chk("R7 class probe", int'(probe_sel), 3);
        waitn(30);  chk("R4 pass at 151 grant", int'(grant_pwr), 1);
        chk("R8 code at 6500", int'(class_code), 1);

        start(100, 250, 6500, 1, 0, 0);
        waitn(220); chk("R4 fail at 150 grant", int'(grant_pwr), 0);
        chk("R5 retry probe", int'(probe_sel), 1);

        // upper window edge, top class range
        start(0, 210, 46500, 1, 0, 0);
        waitn(88);  chk("R2 last low cycle", int'(probe_sel), 1);
        waitn(1);   chk("R2 switch to high", int'(probe_sel), 2);
        waitn(131); chk("R4 pass at 210 grant", int'(grant_pwr), 1);
        chk("R8 code at 46500", int'(class_code), 0);

        start(0, 211, 10000, 1, 0, 0);
        waitn(220); chk("R4 fail at 211 grant", int'(grant_pwr), 0);

        start(300, 100, 10000, 1, 0, 0);
        waitn(220); chk("R4 negative delta grant", int'(grant_pwr), 0);

        for (int k = 0; k < 7; k++) begin
            start(50, 230, cls_in[k], 1, 0, 0);
            waitn(220);
            chk("R8 class bin", int'(class_code), cls_ex[k]);
        end

        start(50, 230, 30000, 0, 0, 0);
        waitn(180); chk("R9 skip grant", int'(grant_pwr), 1);
        chk("R9 skip code", int'(class_code), 6);

        start(0, 100, 0, 1, 1, 0);
        waitn(200);  chk("R6 backoff hiz", int'(probe_sel), 4);
        waitn(2776); chk("R6 backoff end hiz", int'(probe_sel), 4);
        waitn(2);    chk("R6 resume low probe", int'(probe_sel), 1);

        start(0, 0, 0, 1, 0, 1);
        waitn(1);  chk("R10 bypass grant", int'(grant_pwr), 1);
        chk("R10 bypass code", int'(class_code), 7);
        det_bypass = 0;

        start(50, 230, 10000, 1, 0, 0);
        waitn(100); uv_ok = 0;
        waitn(1);   chk("R11 uv drop probe", int'(probe_sel), 0);
        chk("R11 uv drop code", int'(class_code), 7);
        uv_ok = 1;

        start(50, 230, 10000, 0, 0, 0);
        waitn(200); chk("R9 powered before drop", int'(grant_pwr), 1);
        enable = 0;
        waitn(1);   chk("R11 enable drop grant", int'(grant_pwr), 0);

        tick_mode = 0;
        start(50, 230, 20000, 1, 0, 0);
        waitn(300); chk("R12 no tick holds probe", int'(probe_sel), 1);
        tick_mode = 1;
        waitn(220); chk("R7 grant after ticks resume", int'(grant_pwr), 1);

        tick_mode = 2;
        start(50, 230, 20000, 1, 0, 0);
        waitn(300); chk("R12 sparse tick still detecting", int'(grant_pwr), 0);
        waitn(400); chk("R7 sparse tick grant", int'(grant_pwr), 1);
        chk("R8 sparse tick code", int'(class_code), 2);
        tick_mode = 1;

        finish_run();
    end
endmodule